// File: doc/BRIEF.md
# Event-Metered Multi-Channel DMA Request Controller

This block arbitrates among a set of DMA channels and moves one data item at a time over a single-beat memory handshake. Each channel holds a memory address, a remaining-item count, an event-metering mode bit, an interrupt enable and a sticky transfer-error flag. One transfer is in flight at most. When the handshake is idle, the controller picks the lowest-numbered channel that may move an item, checks its address against a shared base/limit window and then either presents a request to memory or halts the channel with an address fault.

A channel in event-metering mode ignores its peripheral request line. Each hardware event pulse grants it a single-item credit, and that credit alone is enough to start a transfer. An event that arrives while a credit is still pending, or while that channel's item is in flight, is dropped and reported as an overflow pulse. A faulted channel stays halted until software writes its address again and then strobes the error-clear bit.

Software reaches the channel registers through simple write strobes that share one channel select. The interrupt output is the OR of every channel's error flag that has its interrupt enabled.

Top module: `evdma_ctrl`

## Requirements
- R1: When several channels are eligible in the same idle cycle, the channel with the lowest index is granted. The grant drives `mem_valid` high and puts that channel's address and index on `mem_addr` and `mem_ch` in the next cycle.
- R2: At grant, an address below `win_base` or above `win_limit` is a fault. No memory request is issued. The channel's `err_flag` bit rises and its `err_pulse` bit is high for exactly one cycle.
- R3: A completion with `mem_err` high is a fault with the same effects as R2. The channel's address and remaining count are not advanced.
- R4: A faulted channel ignores its requests and ignores error-clear strobes until its address register has been written. After that write, an error-clear strobe drops `err_flag` and the channel may transfer again.
- R5: `irq` is high exactly when some channel has both its error flag and its interrupt enable set. Clearing the enable drops `irq` in the cycle after the write.
- R6: With event mode on and no credit pending, a channel is never granted, whatever its peripheral request line does.
- R7: In event mode each event pulse allows exactly one item. The item starts even when the peripheral request line is low. The grant comes one cycle after the event is registered.
- R8: An event to a channel in event mode that arrives while a credit is pending, or while that channel's item is in flight, raises that channel's `ovf_pulse` for one cycle and grants no credit.
- R9: Each successful completion adds `ITEM_BYTES` to the channel's address and subtracts one from its count. A channel with count zero is never granted, and its `done` bit is high.
- R10: Writing the mode with event mode off clears any pending credit. Turning event mode back on therefore starts no transfer until a new event arrives.
- R11: Only one transfer is in flight. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_ch` hold. The completion cycle ends the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ch | input | CHW | Channel selected by the write strobes |
| cfg_addr_we | input | 1 | Write strobe for the address register |
| cfg_addr | input | AW | Address write data |
| cfg_cnt_we | input | 1 | Write strobe for the remaining-item count |
| cfg_cnt | input | CNTW | Count write data |
| cfg_mode_we | input | 1 | Write strobe for the mode bits |
| cfg_evmode | input | 1 | Event-metering mode write data |
| cfg_irqen | input | 1 | Interrupt enable write data |
| cfg_eclr | input | 1 | Error-clear strobe |
| win_base | input | AW | Lowest valid address |
| win_limit | input | AW | Highest valid address |
| per_req | input | NCH | Peripheral request levels, one per channel |
| evt | input | NCH | Hardware event pulses, one per channel |
| mem_valid | output | 1 | Memory request valid |
| mem_addr | output | AW | Memory request address |
| mem_ch | output | CHW | Channel that owns the request |
| mem_ready | input | 1 | Memory completes the request |
| mem_err | input | 1 | Error response, sampled with `mem_ready` |
| done | output | NCH | Count is zero, per channel |
| err_flag | output | NCH | Sticky transfer-error flag, per channel |
| err_pulse | output | NCH | One-cycle pulse when a fault occurs |
| ovf_pulse | output | NCH | One-cycle pulse when an event is dropped |
| irq | output | 1 | Interrupt request |

## Verification
Arbitration is tried with every non-empty request mask over four channels. Each mask confirms the lowest-index winner and the per-channel address stepping, and it tells a priority error apart from an address error. The window check is swept over addresses just below, at and just above both window edges, plus the extremes, which separates off-by-one compares from a correct inclusive window. The event path is driven in four ways: a held request without an event, an event without a request, a second event during a stalled transfer, and an event followed by a mode toggle. Together these separate gating, metering, overflow and credit clearing. A memory error response is followed by a recovery transfer, which shows that the count was not consumed.

// File: rtl/evdma_pkg.sv
package evdma_pkg;

  typedef enum logic {XS_IDLE = 1'b0, XS_BUSY = 1'b1} xfer_state_e;

  // inclusive address window test, operands zero-extended by callers
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/evdma_arb.sv
module evdma_arb #(
  parameter int N   = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);

  // isolate lowest set bit
  assign gnt = req & (~req + 1'b1);
  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (gnt[i]) idx = IW'(i);
    end
  end

  // R1
  arb_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ($onehot0(gnt) && ((gnt & req) == gnt) && (((gnt - 1'b1) & req) == '0)));

endmodule

// File: rtl/evdma_chan.sv
module evdma_chan #(
  parameter int AW         = 16,
  parameter int CNTW       = 8,
  parameter int ITEM_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr_we,
  input  logic            cnt_we,
  input  logic            mode_we,
  input  logic            eclr_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [CNTW-1:0] cfg_cnt,
  input  logic            cfg_evmode,
  input  logic            cfg_irqen,
  input  logic            req_i,
  input  logic            evt_i,
  input  logic            grant_i,
  input  logic            ok_i,
  input  logic            fault_i,
  input  logic            busy_i,
  output logic [AW-1:0]   addr_o,
  output logic            elig_o,
  output logic            err_o,
  output logic            irq_o,
  output logic            done_o,
  output logic            err_pulse_o,
  output logic            ovf_pulse_o
);

  logic [AW-1:0]   addr;
  logic [CNTW-1:0] cnt;
  logic            evmode, irqen, credit, err, addr_ok;
  logic            ovf_now, credit_set;

  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + AW'(ITEM_BYTES);
  endfunction

  function automatic logic [CNTW-1:0] cnt_step(input logic [CNTW-1:0] c);
    return c - 1'b1;
  endfunction

  // named event wires
  assign ovf_now    = evmode && evt_i && (credit || busy_i);
  assign credit_set = evmode && evt_i && !credit && !busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr        <= '0;
      cnt         <= '0;
      evmode      <= 1'b0;
      irqen       <= 1'b0;
      credit      <= 1'b0;
      err         <= 1'b0;
      addr_ok     <= 1'b0;
      err_pulse_o <= 1'b0;
      ovf_pulse_o <= 1'b0;
    end else begin
      if (addr_we)   addr <= cfg_addr;
      else if (ok_i) addr <= addr_step(addr);

      if (cnt_we)    cnt <= cfg_cnt;
      else if (ok_i) cnt <= cnt_step(cnt);

      if (mode_we) begin
        evmode <= cfg_evmode;
        irqen  <= cfg_irqen;
      end

      if (mode_we && !cfg_evmode) credit <= 1'b0;
      else if (grant_i)           credit <= 1'b0;
      else if (credit_set)        credit <= 1'b1;

      if (fault_i) begin
        err     <= 1'b1;
        addr_ok <= 1'b0;
      end else begin
        if (addr_we)            addr_ok <= 1'b1;
        if (eclr_we && addr_ok) err     <= 1'b0;
      end

      err_pulse_o <= fault_i;
      ovf_pulse_o <= ovf_now;
    end
  end

  assign elig_o = !err && (cnt != '0) && (evmode ? credit : req_i);
  assign addr_o = addr;
  assign err_o  = err;
  assign irq_o  = err && irqen;
  assign done_o = (cnt == '0);

  // R2
  fault_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (err_o && err_pulse_o));

  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !eclr_we) |=> err);

  // R6
  evgate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evmode && !credit) |-> !elig_o);

  // R8
  ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evmode && evt_i && busy_i) |=> ovf_pulse_o);

  // R9
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_i && !addr_we) |=> (addr == $past(addr) + AW'(ITEM_BYTES)));

  // R10
  credit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && !cfg_evmode) |=> !credit);

endmodule

// File: rtl/evdma_ctrl.sv
module evdma_ctrl #(
  parameter int NCH        = 4,
  parameter int AW         = 16,
  parameter int CNTW       = 8,
  parameter int ITEM_BYTES = 4,
  localparam int CHW       = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic            cfg_addr_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic            cfg_cnt_we,
  input  logic [CNTW-1:0] cfg_cnt,
  input  logic            cfg_mode_we,
  input  logic            cfg_evmode,
  input  logic            cfg_irqen,
  input  logic            cfg_eclr,
  input  logic [AW-1:0]   win_base,
  input  logic [AW-1:0]   win_limit,
  input  logic [NCH-1:0]  per_req,
  input  logic [NCH-1:0]  evt,
  output logic            mem_valid,
  output logic [AW-1:0]   mem_addr,
  output logic [CHW-1:0]  mem_ch,
  input  logic            mem_ready,
  input  logic            mem_err,
  output logic [NCH-1:0]  done,
  output logic [NCH-1:0]  err_flag,
  output logic [NCH-1:0]  err_pulse,
  output logic [NCH-1:0]  ovf_pulse,
  output logic            irq
);
  import evdma_pkg::*;

  xfer_state_e    state;
  logic [CHW-1:0] act_ch;
  logic [AW-1:0]  act_addr;

  logic [AW-1:0]  ch_addr [NCH];
  logic [NCH-1:0] elig, gnt_oh, irq_vec;
  logic [NCH-1:0] grant_vec, ok_vec, fault_vec, busy_vec;
  logic [CHW-1:0] gidx;
  logic           gany, grant_go, win_ok, cpl;

  // arbitration among eligible channels, only while idle
  evdma_arb #(.N(NCH)) u_arb (
    .clk (clk),
    .rst_n (rst_n),
    .req (elig & {NCH{state == XS_IDLE}}),
    .gnt (gnt_oh),
    .idx (gidx),
    .any (gany)
  );

  assign grant_go = gany;
  assign win_ok   = in_window(32'(ch_addr[gidx]), 32'(win_base), 32'(win_limit));
  assign cpl      = (state == XS_BUSY) && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= XS_IDLE;
      act_ch   <= '0;
      act_addr <= '0;
    end else if (state == XS_IDLE) begin
      if (grant_go && win_ok) begin
        state    <= XS_BUSY;
        act_ch   <= gidx;
        act_addr <= ch_addr[gidx];
      end
    end else if (mem_ready) begin
      state <= XS_IDLE;
    end
  end

  assign mem_valid = (state == XS_BUSY);
  assign mem_addr  = act_addr;
  assign mem_ch    = act_ch;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel          = (cfg_ch == CHW'(i));
    assign busy_vec[i]  = (state == XS_BUSY) && (act_ch == CHW'(i));
    assign grant_vec[i] = grant_go && gnt_oh[i];
    assign ok_vec[i]    = cpl && busy_vec[i] && !mem_err;
    assign fault_vec[i] = (grant_vec[i] && !win_ok) || (cpl && busy_vec[i] && mem_err);

    evdma_chan #(.AW(AW), .CNTW(CNTW), .ITEM_BYTES(ITEM_BYTES)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_we     (cfg_addr_we && sel),
      .cnt_we      (cfg_cnt_we && sel),
      .mode_we     (cfg_mode_we && sel),
      .eclr_we     (cfg_eclr && sel),
      .cfg_addr    (cfg_addr),
      .cfg_cnt     (cfg_cnt),
      .cfg_evmode  (cfg_evmode),
      .cfg_irqen   (cfg_irqen),
      .req_i       (per_req[i]),
      .evt_i       (evt[i]),
      .grant_i     (grant_vec[i]),
      .ok_i        (ok_vec[i]),
      .fault_i     (fault_vec[i]),
      .busy_i      (busy_vec[i]),
      .addr_o      (ch_addr[i]),
      .elig_o      (elig[i]),
      .err_o       (err_flag[i]),
      .irq_o       (irq_vec[i]),
      .done_o      (done[i]),
      .err_pulse_o (err_pulse[i]),
      .ovf_pulse_o (ovf_pulse[i])
    );
  end

  assign irq = |irq_vec;

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_ch)));

  // R3
  resp_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_err) |=> (!mem_valid && err_flag[$past(mem_ch)]));

  // R5
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (err_flag != '0));

  // R2
  no_req_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_valid && (fault_vec != '0)) |=> !mem_valid);

endmodule

// File: tb/evdma_ctrl_tb.sv
`timescale 1ns/1ps
module evdma_ctrl_tb;
  localparam int NCH = 4, AW = 16, CNTW = 8, ITEM = 4, CHW = 2;
  localparam logic [AW-1:0] BASE = 16'h0100, LIMIT = 16'h01FF;

  logic clk = 0, rst_n = 0;
  logic [CHW-1:0] cfg_ch = 0;
  logic cfg_addr_we = 0, cfg_cnt_we = 0, cfg_mode_we = 0, cfg_evmode = 0, cfg_irqen = 0, cfg_eclr = 0;
  logic [AW-1:0] cfg_addr = 0;
  logic [CNTW-1:0] cfg_cnt = 0;
  logic [NCH-1:0] per_req = 0, evt = 0;
  logic mem_ready = 0, mem_err = 0;
  logic mem_valid, irq;
  logic [AW-1:0] mem_addr;
  logic [CHW-1:0] mem_ch;
  logic [NCH-1:0] done, err_flag, err_pulse, ovf_pulse;

  int checks = 0, errors = 0;
  int xfer_cnt [NCH];
  logic [AW-1:0] exp_addr [NCH];

  always #4 clk = ~clk;

  evdma_ctrl #(.NCH(NCH), .AW(AW), .CNTW(CNTW), .ITEM_BYTES(ITEM)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ch(cfg_ch), .cfg_addr_we(cfg_addr_we), .cfg_addr(cfg_addr),
    .cfg_cnt_we(cfg_cnt_we), .cfg_cnt(cfg_cnt), .cfg_mode_we(cfg_mode_we), .cfg_evmode(cfg_evmode),
    .cfg_irqen(cfg_irqen), .cfg_eclr(cfg_eclr), .win_base(BASE), .win_limit(LIMIT),
    .per_req(per_req), .evt(evt), .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_ch(mem_ch),
    .mem_ready(mem_ready), .mem_err(mem_err), .done(done), .err_flag(err_flag),
    .err_pulse(err_pulse), .ovf_pulse(ovf_pulse), .irq(irq));

  // completed items per channel, observed at the ports
  always @(negedge clk) if (rst_n && mem_valid && mem_ready) xfer_cnt[mem_ch]++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_addr(input int c, input logic [AW-1:0] a);
    cfg_ch = CHW'(c); cfg_addr = a; cfg_addr_we = 1; @(negedge clk); cfg_addr_we = 0;
  endtask
  task automatic wr_cnt(input int c, input logic [CNTW-1:0] n);
    cfg_ch = CHW'(c); cfg_cnt = n; cfg_cnt_we = 1; @(negedge clk); cfg_cnt_we = 0;
  endtask
  task automatic wr_mode(input int c, input logic ev, input logic ie);
    cfg_ch = CHW'(c); cfg_evmode = ev; cfg_irqen = ie; cfg_mode_we = 1; @(negedge clk); cfg_mode_we = 0;
  endtask
  task automatic wr_eclr(input int c);
    cfg_ch = CHW'(c); cfg_eclr = 1; @(negedge clk); cfg_eclr = 0;
  endtask
  task automatic finish_one();
    mem_ready = 1; @(negedge clk); mem_ready = 0;
  endtask
  task automatic pulse_evt(input int c);
    evt[c] = 1; @(negedge clk); evt = 0;
  endtask

  initial begin
    #(8 * 20000);
    errors++; checks++;
    $display("FAIL R11 watchdog actual=%0h expected=%0h", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base_n, any_v, lo;
    logic [AW-1:0] a, held;
    bit fault;
    for (int c = 0; c < NCH; c++) xfer_cnt[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(!mem_valid && !irq && err_flag == 0 && err_pulse == 0 && ovf_pulse == 0, "R9 reset idle", {mem_valid, irq, err_flag}, 0);
    chk(done == 4'hF, "R9 reset done", done, 4'hF);

    for (int c = 0; c < NCH; c++) begin
      exp_addr[c] = BASE + AW'(c * 32);
      wr_addr(c, exp_addr[c]);
      wr_cnt(c, 100);
    end

    // R1 sweep over all request masks, with R9 stepping and R11 hold
    for (int m = 1; m < 16; m++) begin
      lo = 0;
      for (int b = 3; b >= 0; b--) if (m[b]) lo = b;
      per_req = NCH'(m);
      @(negedge clk);
      per_req = 0;
      chk(mem_valid && mem_ch == CHW'(lo), "R1 lowest index wins", mem_ch, lo);
      chk(mem_addr == exp_addr[lo], "R9 address step", mem_addr, exp_addr[lo]);
      held = mem_addr;
      @(negedge clk);
      chk(mem_valid && mem_addr == held && mem_ch == CHW'(lo), "R11 request held", mem_addr, held);
      finish_one();
      exp_addr[lo] = exp_addr[lo] + AW'(ITEM);
      chk(!mem_valid, "R11 request ends", mem_valid, 0);
    end

    // R9 count to zero
    wr_cnt(3, 2);
    base_n = xfer_cnt[3];
    per_req = 4'b1000; mem_ready = 1;
    repeat (10) @(negedge clk);
    per_req = 0; mem_ready = 0;
    chk(xfer_cnt[3] - base_n == 2, "R9 items moved", xfer_cnt[3] - base_n, 2);
    chk(done[3] == 1, "R9 done at zero", done[3], 1);
    exp_addr[3] = exp_addr[3] + AW'(2 * ITEM);
    wr_cnt(3, 1);
    per_req = 4'b1000; @(negedge clk); per_req = 0;
    chk(mem_valid && mem_addr == exp_addr[3], "R9 address after count", mem_addr, exp_addr[3]);
    finish_one();

    // R2 window sweep on channel 2
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: a = BASE - 1;  1: a = BASE;  2: a = LIMIT;
        3: a = LIMIT + 1; 4: a = 16'h0000; default: a = 16'hFFFF;
      endcase
      fault = (a < BASE) || (a > LIMIT);
      wr_addr(2, a);
      wr_eclr(2);
      per_req = 4'b0100; @(negedge clk); per_req = 0;
      if (fault) begin
        chk(err_flag[2] && err_pulse[2] && !mem_valid, "R2 window fault", {err_flag[2], err_pulse[2], mem_valid}, 3'b110);
        @(negedge clk);
        chk(!err_pulse[2] && err_flag[2], "R2 single pulse", {err_pulse[2], err_flag[2]}, 2'b01);
      end else begin
        chk(mem_valid && mem_addr == a && !err_flag[2], "R2 window pass", mem_addr, a);
        finish_one();
      end
    end

    // R4 error clear without a new address is ignored
    wr_eclr(2);
    chk(err_flag[2] == 1, "R4 clear ignored", err_flag[2], 1);
    per_req = 4'b0100;
    any_v = 0;
    repeat (3) begin @(negedge clk); if (mem_valid) any_v = 1; end
    per_req = 0;
    chk(any_v == 0, "R4 halted no transfer", any_v, 0);
    wr_addr(2, 16'h0140);
    wr_eclr(2);
    chk(err_flag[2] == 0, "R4 clear after address", err_flag[2], 0);
    per_req = 4'b0100; @(negedge clk); per_req = 0;
    chk(mem_valid && mem_addr == 16'h0140, "R4 resumes", mem_addr, 16'h0140);
    finish_one();

    // R5 interrupt
    wr_mode(1, 0, 1);
    wr_addr(1, 16'h0300);
    per_req = 4'b0010; @(negedge clk); per_req = 0;
    chk(irq == 1, "R5 irq on fault", irq, 1);
    wr_mode(1, 0, 0);
    chk(irq == 0, "R5 irq masked", irq, 0);
    wr_mode(1, 0, 1);
    chk(irq == 1, "R5 irq unmasked", irq, 1);
    wr_addr(1, 16'h0120);
    wr_eclr(1);
    chk(irq == 0, "R5 irq cleared", irq, 0);

    // R3 error response
    wr_cnt(0, 1);
    wr_addr(0, 16'h0180);
    per_req = 4'b0001; @(negedge clk); per_req = 0;
    chk(mem_valid && mem_ch == 0, "R3 request up", mem_ch, 0);
    mem_ready = 1; mem_err = 1; @(negedge clk); mem_ready = 0; mem_err = 0;
    chk(err_flag[0] && err_pulse[0] && !mem_valid, "R3 response fault", {err_flag[0], err_pulse[0], mem_valid}, 3'b110);
    chk(done[0] == 0, "R3 count kept", done[0], 0);
    wr_addr(0, 16'h0180);
    wr_eclr(0);
    per_req = 4'b0001; @(negedge clk); per_req = 0;
    chk(mem_valid && mem_addr == 16'h0180, "R3 retry address", mem_addr, 16'h0180);
    finish_one();
    chk(done[0] == 1, "R3 count used once", done[0], 1);

    // R6 / R7 event metering on channel 2
    wr_addr(2, 16'h0100);
    wr_cnt(2, 20);
    wr_mode(2, 1, 0);
    per_req = 4'b0100;
    any_v = 0;
    repeat (4) begin @(negedge clk); if (mem_valid) any_v = 1; end
    chk(any_v == 0, "R6 request blocked", any_v, 0);
    pulse_evt(2);
    @(negedge clk);
    chk(mem_valid && mem_ch == 2, "R7 grant after event", mem_ch, 2);
    base_n = xfer_cnt[2];
    mem_ready = 1;
    repeat (6) @(negedge clk);
    mem_ready = 0; per_req = 0;
    chk(xfer_cnt[2] - base_n == 1, "R7 one item per event", xfer_cnt[2] - base_n, 1);
    pulse_evt(2);
    @(negedge clk);
    chk(mem_valid && mem_ch == 2, "R7 event without request", mem_ch, 2);
    finish_one();

    // R8 overflow during an in-flight item
    pulse_evt(2);
    chk(ovf_pulse[2] == 0, "R8 first event no overflow", ovf_pulse[2], 0);
    @(negedge clk);
    pulse_evt(2);
    chk(ovf_pulse[2] == 1, "R8 overflow pulse", ovf_pulse[2], 1);
    @(negedge clk);
    chk(ovf_pulse[2] == 0, "R8 overflow single", ovf_pulse[2], 0);
    finish_one();
    any_v = 0;
    repeat (4) begin @(negedge clk); if (mem_valid) any_v = 1; end
    chk(any_v == 0, "R8 event dropped", any_v, 0);

    // R10 credit cleared by mode off
    wr_cnt(0, 5);
    per_req = 4'b0001; @(negedge clk); per_req = 0;
    pulse_evt(2);
    chk(ovf_pulse[2] == 0, "R10 credit accepted", ovf_pulse[2], 0);
    wr_mode(2, 0, 0);
    wr_mode(2, 1, 0);
    finish_one();
    any_v = 0;
    repeat (4) begin @(negedge clk); if (mem_valid) any_v = 1; end
    chk(any_v == 0, "R10 credit cleared", any_v, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule